// File: doc/BRIEF.md
# Multiple-Register Transfer Address Sequencer

This block sequences a block load or store that moves any subset of up to sixteen registers. The caller supplies a register list as a bitmask, a base address, one of four addressing modes and a writeback flag, and pulses start. The sequencer then issues one beat per cycle. Each beat carries a register index and the word address that register uses. After the last beat it pulses done and presents the updated base value.

The modes differ in where the block sits relative to the base and in which direction the base moves. In every mode the registers are visited in ascending index order at ascending addresses. The order in which a program writes the list therefore has no effect. The two decrement modes begin at the lowest address of the block, not at the base.

The register file, the memory port and the data path stay outside the block. They consume the beat stream.

Top module: `regxfer_seq`

## Requirements
- R1: After reset, busy, beat_valid and done are all low.
- R2: Mode 2'b00 (increment after) places the first beat at address base.
- R3: Mode 2'b01 (increment before) places the first beat at address base+4.
- R4: Mode 2'b10 (decrement after) places the first beat at base-4N+4, where N is the number of set bits in the list.
- R5: Mode 2'b11 (decrement before) places the first beat at base-4N.
- R6: One beat is issued per cycle starting the cycle after start is accepted, with exactly N beats. Register indices are the set bits of the list from bit 0 upward, and each beat's address is 4 above the previous one.
- R7: done is high for exactly the one cycle that follows the last beat, and busy is low in that cycle.
- R8: With the writeback flag set, wb_value at done is base+4N for modes 2'b00 and 2'b01 and base-4N for modes 2'b10 and 2'b11. With the flag clear, wb_value is base.
- R9: An empty list produces no beats. done pulses in the cycle after start, and wb_value equals base.
- R10: A start pulse while busy is high is ignored, and the running operation's beats and result are unchanged.
- R11: A list with all sixteen bits set transfers all sixteen registers, indices 0 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation; accepted only when not busy |
| reg_list | input | 16 | Bitmask of the registers to move |
| base | input | 32 | Base address |
| mode | input | 2 | 00 inc-after, 01 inc-before, 10 dec-after, 11 dec-before |
| wb_en | input | 1 | Report the updated base rather than the original |
| busy | output | 1 | An operation is producing beats |
| beat_valid | output | 1 | A beat is present this cycle |
| beat_reg | output | 4 | Register index of the current beat |
| beat_addr | output | 32 | Word address of the current beat |
| done | output | 1 | One-cycle completion pulse |
| wb_value | output | 32 | Final base value, valid with done |

## Verification
The sequencer is run in all four modes, with and without writeback, over these lists:
- The empty list, which isolates the zero-beat path.
- Each single bit, which shows whether the index encoder and the per-mode start offset are right at every position.
- Sparse and alternating masks, which expose skipped or reordered indices.
- The full mask, which checks the sixteen-beat limit and the 64-byte offset.

A base near zero makes the decrement modes wrap around the address space. One run drives a second start in the middle of an operation to show that it is ignored.

// File: rtl/regxfer_seq.sv
module regxfer_seq #(
  parameter int NREGS = 16,
  parameter int AW    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [NREGS-1:0]         reg_list,
  input  logic [AW-1:0]            base,
  input  logic [1:0]               mode,
  input  logic                     wb_en,
  output logic                     busy,
  output logic                     beat_valid,
  output logic [$clog2(NREGS)-1:0] beat_reg,
  output logic [AW-1:0]            beat_addr,
  output logic                     done,
  output logic [AW-1:0]            wb_value
);
  localparam int IW = $clog2(NREGS);
  localparam int CW = $clog2(NREGS + 1);

  logic [NREGS-1:0] pend;
  logic [AW-1:0]    addr_q, wb_q, span, first_addr;
  logic             busy_q, done_q;
  logic [IW-1:0]    low_idx;
  logic [CW-1:0]    cnt;

  function automatic logic [CW-1:0] popcnt(input logic [NREGS-1:0] v);
    logic [CW-1:0] c;
    c = '0;
    for (int i = 0; i < NREGS; i++) c = c + CW'(v[i]);
    return c;
  endfunction

  always_comb begin
    low_idx = '0;
    for (int i = NREGS - 1; i >= 0; i--)
      if (pend[i]) low_idx = IW'(i);
  end

  assign cnt  = popcnt(reg_list);
  assign span = AW'(cnt) << 2;

  always_comb begin
    unique case (mode)
      2'b00: first_addr = base;
      2'b01: first_addr = base + AW'(4);
      2'b10: first_addr = base - span + AW'(4);
      default: first_addr = base - span;
    endcase
  end

  wire [NREGS-1:0] pend_next = pend & (pend - NREGS'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend   <= '0;
      addr_q <= '0;
      wb_q   <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        pend   <= pend_next;
        addr_q <= addr_q + AW'(4);
        if (pend_next == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (start) begin
        wb_q <= !wb_en ? base : (mode[1] ? base - span : base + span);
        if (reg_list == '0) begin
          done_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          pend   <= reg_list;
          addr_q <= first_addr;
        end
      end
    end
  end

  assign busy       = busy_q;
  assign beat_valid = busy_q;
  assign beat_reg   = low_idx;
  assign beat_addr  = addr_q;
  assign done       = done_q;
  assign wb_value   = wb_q;

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && $past(beat_valid) |-> beat_addr == $past(beat_addr) + AW'(4));
  // R6
  reg_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && $past(beat_valid) |-> beat_reg > $past(beat_reg));
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R10
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(wb_value));
  // R7
  done_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

// File: tb/regxfer_seq_tb.sv
module regxfer_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] reg_list = '0;
  logic [31:0] base = '0;
  logic [1:0]  mode = '0;
  logic        wb_en = 1'b0;
  logic        busy, beat_valid, done;
  logic [3:0]  beat_reg;
  logic [31:0] beat_addr, wb_value;
  int          checks = 0;
  int          fails = 0;

  always #2 clk = ~clk;

  regxfer_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .reg_list(reg_list), .base(base),
    .mode(mode), .wb_en(wb_en), .busy(busy), .beat_valid(beat_valid),
    .beat_reg(beat_reg), .beat_addr(beat_addr), .done(done), .wb_value(wb_value)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [15:0] l, input logic [31:0] b, input logic [1:0] m,
                        input bit w, input bit intrude);
    int n;
    logic [31:0] a;
    logic [31:0] expwb;
    n = $countones(l);
    case (m)
      2'b00: a = b;
      2'b01: a = b + 32'd4;
      2'b10: a = b - 32'(4 * n) + 32'd4;
      default: a = b - 32'(4 * n);
    endcase
    expwb = !w ? b : (m[1] ? b - 32'(4 * n) : b + 32'(4 * n));
    @(negedge clk);
    reg_list = l; base = b; mode = m; wb_en = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 16; i++) begin
      if (l[i]) begin
        if (intrude) begin
          start = 1'b1; reg_list = 16'hFFFF; base = 32'h5555_0000; mode = 2'b11; wb_en = 1'b1;
        end
        chk(beat_valid === 1'b1, "R6 beat_valid", beat_valid, 1);
        chk(busy === 1'b1, "R6 busy", busy, 1);
        chk(beat_reg === 4'(i), (l == 16'hFFFF) ? "R11 beat_reg" : "R6 beat_reg", beat_reg, i);
        chk(beat_addr === a, (m == 2'b00) ? "R2/R6 addr" : (m == 2'b01) ? "R3/R6 addr" :
            (m == 2'b10) ? "R4/R6 addr" : "R5/R6 addr", beat_addr, a);
        if (intrude) chk(wb_value === expwb || i == 0, "R10 wb hold", wb_value, expwb);
        a = a + 32'd4;
        @(negedge clk);
        start = 1'b0;
      end
    end
    chk(done === 1'b1, (n == 0) ? "R9 done" : "R7 done", done, 1);
    chk(beat_valid === 1'b0, (n == 0) ? "R9 no beat" : "R7 no beat", beat_valid, 0);
    chk(busy === 1'b0, "R7 busy low", busy, 0);
    chk(wb_value === expwb, intrude ? "R10 wb" : (n == 0) ? "R9 wb" : "R8 wb", wb_value, expwb);
    @(negedge clk);
    chk(done === 1'b0, "R7 done single", done, 0);
    chk(beat_valid === 1'b0, intrude ? "R10 no extra beat" : "R7 idle", beat_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R1 busy", busy, 0);
    chk(beat_valid === 1'b0, "R1 beat_valid", beat_valid, 0);
    chk(done === 1'b0, "R1 done", done, 0);
    rst_n = 1'b1;
    for (int m = 0; m < 4; m++) begin
      for (int w = 0; w < 2; w++) begin
        run_op(16'h0000, 32'h0000_1000, 2'(m), w[0], 1'b0);
        run_op(16'hFFFF, 32'h0000_1000, 2'(m), w[0], 1'b0);
        run_op(16'h0013, 32'h8000_0040, 2'(m), w[0], 1'b0);
        run_op(16'hA5A5, 32'h0000_0010, 2'(m), w[0], 1'b0);
        run_op(16'h8001, 32'h0000_0000, 2'(m), w[0], 1'b0);
      end
      for (int b = 0; b < 16; b++)
        run_op(16'(1 << b), 32'h0000_2000 + 32'(b * 8), 2'(m), 1'b1, 1'b0);
      run_op(16'h00F0, 32'h0000_3000, 2'(m), 1'b1, 1'b1);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule